// File: doc/BRIEF.md
# Reconfigurable Multi-TAP Scan Chain

This block is a serial test-access chain built from several TAP controllers in the IEEE 1149.1 style. All of them share one test clock, one mode-select line and one active-low test reset. After reset only two TAPs sit between the serial input and the serial output: a boundary-scan TAP, followed by a chip TAP. The chip TAP holds a small enable register. Writing that register splices up to three further sub-TAPs into the serial path, each of them optional: a switch TAP, a core-debug TAP and a fuse-programming (OTP) TAP.

A debugger uses the block as follows. It loads the chain-select instruction into the chip TAP and shifts an enable mask through that TAP's data register. From the next scan onward the chain is longer by the selected TAPs. The core-debug TAP reaches a small register file through a command data register that carries a write flag, an address and data. The switch TAP, the OTP TAP and the boundary-scan TAP each carry a placeholder register that keeps whatever was last written to it. Five clocks with the mode-select line held high return every TAP to its reset state, and this also drops all sub-TAPs out of the chain.

Top module: `jtag_multi_tap_chain`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, every TAP goes to Test-Logic-Reset, every instruction register returns to BYPASS, the sub-TAP enables clear, the core register file and the placeholder registers clear, and `tdo`/`tdo_oe` read 0. Holding it low for 4 clocks is enough.
- R2: Straight after reset the instruction-register chain is 8 bits long and the data-register chain is 2 bits long.
- R3: In Capture-IR every active TAP loads 4'b0001. The first bits shifted out are therefore 1,0,0,0 for each TAP, least significant bit first.
- R4: Instruction 4'b0010 in the chip TAP selects a 3-bit enable register. Bit 0 enables the switch TAP, bit 1 the core TAP and bit 2 the OTP TAP. Capture returns the current mask. A new mask takes effect only in Update-DR.
- R5: The order from `tdi` to `tdo` is boundary-scan, chip, switch, core, OTP. A disabled sub-TAP adds no bits. With n sub-TAPs enabled, the IR chain is 8+4n bits and the all-BYPASS DR chain is 2+n bits.
- R6: Five rising edges with `tms` high bring every TAP to Test-Logic-Reset and clear the enable mask. All TAP controllers step in lockstep.
- R7: Instruction 4'b0100 in the core TAP selects an 11-bit command register {wr[10], addr[9:8], data[7:0]}. Every Update-DR latches addr as the read address, and when wr=1 it also writes data to that address. Capture-DR returns {0, read address, register[read address]}.
- R8: Placeholder registers keep the value written at Update-DR and return it at the next Capture-DR. Boundary-scan uses code 4'b0000 with 8 bits, the switch TAP code 4'b0011 with 5 bits, and the OTP TAP code 4'b0101 with 7 bits.
- R9: `tdo` changes on the falling edge of `tck`. `tdo_oe` is high only while the TAPs are in Shift-IR or Shift-DR, and `tdo` reads 0 whenever `tdo_oe` is low.
- R10: Instructions load only in Update-IR. BYPASS is 4'b1111 and selects a 1-bit register that captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; controllers step on the rising edge |
| trst_n | input | 1 | Test reset, active low, sampled on rising `tck` |
| tms | input | 1 | Test mode select shared by all TAPs |
| tdi | input | 1 | Serial data into the boundary-scan TAP |
| tdo | output | 1 | Serial data out of the last active TAP |
| tdo_oe | output | 1 | High while shifting; marks `tdo` as driven |

## Verification
The bench builds the block with its default widths: an 8-bit boundary placeholder, a 5-bit switch placeholder, a 7-bit OTP placeholder and the 11-bit core command register with four 8-bit registers. These sizes keep every chain shorter than 50 bits. A 50-bit flush ahead of a single marker bit therefore measures every length exactly, for all eight enable masks. The sub-TAP widths all differ, so a wrongly ordered splice shifts a placeholder read-back off its expected bit position and is caught.

// File: rtl/jtag_chain_pkg.sv
package jtag_chain_pkg;

    localparam int IR_W = 4;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
    localparam logic [IR_W-1:0] IR_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] OP_BSCAN   = 4'b0000;
    localparam logic [IR_W-1:0] OP_CHAIN   = 4'b0010;
    localparam logic [IR_W-1:0] OP_SWITCH  = 4'b0011;
    localparam logic [IR_W-1:0] OP_CORE    = 4'b0100;
    localparam logic [IR_W-1:0] OP_OTP     = 4'b0101;

    localparam int N_SUB   = 3;
    localparam int CORE_AW = 2;
    localparam int CORE_DW = 8;
    localparam int CORE_W  = 1 + CORE_AW + CORE_DW;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    typedef struct packed {
        logic               wr;
        logic [CORE_AW-1:0] addr;
        logic [CORE_DW-1:0] data;
    } core_cmd_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            TLR:    n = tms ? TLR    : RTI;
            RTI:    n = tms ? SEL_DR : RTI;
            SEL_DR: n = tms ? SEL_IR : CAP_DR;
            CAP_DR: n = tms ? EX1_DR : SH_DR;
            SH_DR:  n = tms ? EX1_DR : SH_DR;
            EX1_DR: n = tms ? UPD_DR : PAU_DR;
            PAU_DR: n = tms ? EX2_DR : PAU_DR;
            EX2_DR: n = tms ? UPD_DR : SH_DR;
            UPD_DR: n = tms ? SEL_DR : RTI;
            SEL_IR: n = tms ? TLR    : CAP_IR;
            CAP_IR: n = tms ? EX1_IR : SH_IR;
            SH_IR:  n = tms ? EX1_IR : SH_IR;
            EX1_IR: n = tms ? UPD_IR : PAU_IR;
            PAU_IR: n = tms ? EX2_IR : PAU_IR;
            EX2_IR: n = tms ? UPD_IR : SH_IR;
            UPD_IR: n = tms ? SEL_DR : RTI;
            default: n = TLR;
        endcase
        return n;
    endfunction

    function automatic logic is_shift(tap_state_e s);
        return (s == SH_IR) || (s == SH_DR);
    endfunction

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_chain_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= TLR;
        else     state <= tap_next(state, tms);
    end

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
    import jtag_chain_pkg::*;
#(
    parameter int              DR_W  = 8,
    parameter logic [IR_W-1:0] DR_OP = OP_BSCAN
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tms,
    input  logic            tdi,
    input  logic            active,
    input  logic [DR_W-1:0] dr_cap,
    output tap_state_e      state,
    output logic [DR_W-1:0] dr_val,
    output logic            dr_upd,
    output logic            tdo_q
);

    logic [IR_W-1:0] ir;
    logic [IR_W-1:0] ir_sr;
    logic [DR_W-1:0] dr_sr;
    logic            byp;
    logic            sel;

    jtag_tap_ctrl u_ctrl (.tck(tck), .rst(rst), .tms(tms), .state(state));

    assign sel    = (ir == DR_OP);
    assign dr_upd = active && sel && (state == UPD_DR);
    assign dr_val = dr_sr;

    always_ff @(posedge tck) begin
        if (rst || !active || state == TLR) begin
            ir    <= IR_BYPASS;
            ir_sr <= '0;
            dr_sr <= '0;
            byp   <= 1'b0;
        end else begin
            case (state)
                CAP_IR: ir_sr <= IR_CAPTURE;
                SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                UPD_IR: ir    <= ir_sr;
                CAP_DR: begin
                    if (sel) dr_sr <= dr_cap;
                    else     byp   <= 1'b0;
                end
                SH_DR: begin
                    if (sel) dr_sr <= {tdi, dr_sr[DR_W-1:1]};
                    else     byp   <= tdi;
                end
                default: ;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (rst)                 tdo_q <= 1'b0;
        else if (state == SH_IR) tdo_q <= ir_sr[0];
        else if (state == SH_DR) tdo_q <= sel ? dr_sr[0] : byp;
    end

endmodule

// File: rtl/jtag_sub_tap.sv
module jtag_sub_tap
    import jtag_chain_pkg::*;
#(
    parameter int              DR_W    = 5,
    parameter logic [IR_W-1:0] DR_OP   = OP_SWITCH,
    parameter bit              IS_CORE = 1'b0
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    input  logic       tdi,
    input  logic       active,
    output tap_state_e state,
    output logic       tdo_q
);

    logic [DR_W-1:0] cap;
    logic [DR_W-1:0] dval;
    logic            upd;

    jtag_tap #(.DR_W(DR_W), .DR_OP(DR_OP)) u_tap (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .active(active),
        .dr_cap(cap), .state(state), .dr_val(dval), .dr_upd(upd), .tdo_q(tdo_q)
    );

    generate
        if (IS_CORE) begin : g_core
            localparam int NREG = 1 << CORE_AW;
            logic [CORE_DW-1:0] rf [NREG];
            logic [CORE_AW-1:0] rd_addr;
            core_cmd_t          cmd;

            assign cmd = core_cmd_t'(dval);
            assign cap = {1'b0, rd_addr, rf[rd_addr]};

            always_ff @(posedge tck) begin
                if (rst) begin
                    rd_addr <= '0;
                    for (int k = 0; k < NREG; k++) rf[k] <= '0;
                end else if (upd) begin
                    rd_addr <= cmd.addr;
                    if (cmd.wr) rf[cmd.addr] <= cmd.data;
                end
            end
        end else begin : g_hold
            logic [DR_W-1:0] hold;
            assign cap = hold;
            always_ff @(posedge tck) begin
                if (rst)      hold <= '0;
                else if (upd) hold <= dval;
            end
        end
    endgenerate

endmodule

// File: rtl/jtag_multi_tap_chain.sv
module jtag_multi_tap_chain
    import jtag_chain_pkg::*;
#(
    parameter int BS_W  = 8,
    parameter int SW_W  = 5,
    parameter int OTP_W = 7
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe
);

    localparam int EN_W = N_SUB;

    logic               rst;
    tap_state_e         bs_state;
    tap_state_e         chip_state;
    tap_state_e         sub_state [N_SUB];
    logic [N_SUB*4-1:0] sub_state_v;
    logic [EN_W-1:0]    sub_en;
    logic [EN_W-1:0]    chip_dr;
    logic               chip_upd;
    logic [BS_W-1:0]    bs_hold;
    logic [BS_W-1:0]    bs_dr;
    logic               bs_upd;
    logic               bs_tdo;
    logic [N_SUB-1:0]   sub_tdo;
    logic [N_SUB:0]     node;

    assign rst = ~trst_n;

    jtag_tap #(.DR_W(BS_W), .DR_OP(OP_BSCAN)) u_bs (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .active(1'b1),
        .dr_cap(bs_hold), .state(bs_state), .dr_val(bs_dr), .dr_upd(bs_upd), .tdo_q(bs_tdo)
    );

    always_ff @(posedge tck) begin
        if (rst)         bs_hold <= '0;
        else if (bs_upd) bs_hold <= bs_dr;
    end

    jtag_tap #(.DR_W(EN_W), .DR_OP(OP_CHAIN)) u_chip (
        .tck(tck), .rst(rst), .tms(tms), .tdi(bs_tdo), .active(1'b1),
        .dr_cap(sub_en), .state(chip_state), .dr_val(chip_dr), .dr_upd(chip_upd), .tdo_q(node[0])
    );

    always_ff @(posedge tck) begin
        if (rst || chip_state == TLR) sub_en <= '0;
        else if (chip_upd)            sub_en <= chip_dr;
    end

    generate
        for (genvar i = 0; i < N_SUB; i++) begin : g_sub
            localparam int W = (i == 0) ? SW_W : ((i == 1) ? CORE_W : OTP_W);
            localparam logic [IR_W-1:0] OP = (i == 0) ? OP_SWITCH :
                                             ((i == 1) ? OP_CORE : OP_OTP);
            jtag_sub_tap #(.DR_W(W), .DR_OP(OP), .IS_CORE(i == 1)) u_sub (
                .tck(tck), .rst(rst), .tms(tms), .tdi(node[i]), .active(sub_en[i]),
                .state(sub_state[i]), .tdo_q(sub_tdo[i])
            );
            assign node[i+1] = sub_en[i] ? sub_tdo[i] : node[i];
            assign sub_state_v[4*i +: 4] = sub_state[i];
        end
    endgenerate

    always_ff @(negedge tck) begin
        if (rst) tdo_oe <= 1'b0;
        else     tdo_oe <= is_shift(chip_state);
    end

    assign tdo = tdo_oe & node[N_SUB];

endmodule

// File: rtl/jtag_chain_checker.sv
module jtag_chain_checker
    import jtag_chain_pkg::*;
#(
    parameter int N = 3
) (
    input logic           tck,
    input logic           trst_n,
    input logic           tms,
    input logic           tdo_oe,
    input tap_state_e     chip_state,
    input tap_state_e     bs_state,
    input logic [N*4-1:0] sub_state_v,
    input logic [N-1:0]   sub_en
);

    logic [3:0] cs;
    assign cs = chip_state;

    assert_en_hold_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (chip_state != UPD_DR && chip_state != TLR) |=> $stable(sub_en))
        else $error("enable mask moved outside Update-DR");

    assert_tlr_clear_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (chip_state == TLR) |=> (sub_en == '0))
        else $error("enable mask survived Test-Logic-Reset");

    assert_tlr_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (chip_state == TLR && tms) |=> (chip_state == TLR))
        else $error("left Test-Logic-Reset with tms high");

    assert_lockstep_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (bs_state == chip_state) && (sub_state_v == {N{cs}}))
        else $error("TAP controllers out of step");

    assert_oe_shift_R9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == is_shift(chip_state))
        else $error("tdo_oe disagrees with shift state");

endmodule

bind jtag_multi_tap_chain jtag_chain_checker #(.N(jtag_chain_pkg::N_SUB)) u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_oe(tdo_oe),
    .chip_state(chip_state), .bs_state(bs_state),
    .sub_state_v(sub_state_v), .sub_en(sub_en)
);

// File: tb/jtag_multi_tap_chain_tb_top.sv
`timescale 1ns/1ps
module jtag_multi_tap_chain_tb_top;
    import jtag_chain_pkg::*;

    localparam int TRST_HOLD = 4;
    localparam int WATCHDOG  = 150000;
    localparam int FLUSH     = 50;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe;
    int checks = 0, errors = 0, oe_bad = 0;
    logic [2:0] en_m = '0;
    logic [CORE_DW-1:0] rf_m [4];
    logic [CORE_AW-1:0] rd_m = '0;

    always #2.5 tck = ~tck;

    jtag_multi_tap_chain dut_i (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
                                .tdo(tdo), .tdo_oe(tdo_oe));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        o = tdo; tms = m; tdi = d;
    endtask

    task automatic scan(input bit is_ir, input int n, input logic [127:0] din,
                        output logic [127:0] dout);
        logic o;
        dout = '0;
        step(1'b1, 1'b0, o);
        if (is_ir) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
            if (!tdo_oe) oe_bad++;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    function automatic bit present(input int t);
        return (t < 2) || en_m[t-2];
    endfunction

    task automatic ir_sel(input int which, input logic [3:0] op);
        logic [127:0] din, dout;
        logic [3:0] code;
        int pos = 0;
        din = '1;
        for (int t = 4; t >= 0; t--) begin
            if (present(t)) begin
                code = (t == which) ? op : IR_BYPASS;
                for (int b = 0; b < 4; b++) din[pos+b] = code[b];
                pos += 4;
            end
        end
        scan(1'b1, pos, din, dout);
    endtask

    task automatic dr_sel(input int which, input int w, input logic [15:0] pay,
                          output logic [15:0] cap);
        logic [127:0] din, dout;
        int pos = 0, p0 = 0;
        din = '0;
        cap = '0;
        for (int t = 4; t >= 0; t--) begin
            if (present(t)) begin
                if (t == which) begin
                    p0 = pos;
                    for (int b = 0; b < w; b++) din[pos+b] = pay[b];
                    pos += w;
                end else pos += 1;
            end
        end
        scan(1'b0, pos, din, dout);
        for (int b = 0; b < w; b++) cap[b] = dout[p0+b];
    endtask

    task automatic set_en(input logic [2:0] mask);
        logic [15:0] cap;
        ir_sel(1, OP_CHAIN);
        dr_sel(1, 3, {13'b0, mask}, cap);
        chk("R4 enable capture", {16'b0, cap}, {29'b0, en_m});
        en_m = mask;
    endtask

    task automatic meas(input bit is_ir, output int len);
        logic [127:0] din, dout;
        din = is_ir ? '1 : '0;
        din[FLUSH] = is_ir ? 1'b0 : 1'b1;
        scan(is_ir, 100, din, dout);
        len = -1;
        for (int i = FLUSH; i < 100; i++)
            if (len < 0 && dout[i] == (is_ir ? 1'b0 : 1'b1)) len = i - FLUSH;
    endtask

    task automatic check_lengths(input string tag);
        int li, ld, n;
        n = int'(en_m[0]) + int'(en_m[1]) + int'(en_m[2]);
        meas(1'b1, li);
        chk({tag, " IR length"}, li, 8 + 4 * n);
        meas(1'b0, ld);
        chk({tag, " DR length"}, ld, 2 + n);
    endtask

    task automatic do_reset();
        trst_n = 1'b0; tms = 1'b1;
        repeat (TRST_HOLD) @(negedge tck);
        #1;
        chk("R1 tdo_oe in reset", {31'b0, tdo_oe}, 0);
        chk("R1 tdo in reset", {31'b0, tdo}, 0);
        trst_n = 1'b1;
        en_m = '0; rd_m = '0;
        for (int k = 0; k < 4; k++) rf_m[k] = '0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge tck);
        errors++; checks++;
        $display("FAIL watchdog R1..R10 run actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic o;
        logic [127:0] dout;
        logic [15:0] cap, v, v2;
        int seed;
        seed = $urandom(7919);
        do_reset();
        step(1'b0, 1'b0, o);
        chk("R9 idle tdo_oe", {31'b0, tdo_oe}, 0);

        check_lengths("R2 after reset");

        scan(1'b1, 8, '1, dout);
        chk("R3 IR capture pattern", {24'b0, dout[7:0]}, 32'h11);

        scan(1'b0, 2, 128'h3, dout);
        chk("R10 bypass captures 0", {30'b0, dout[1:0]}, 0);

        set_en(3'b111);
        check_lengths("R5 all enabled");
        set_en(3'b000);
        check_lengths("R5 none enabled");
        for (int it = 0; it < 6; it++) begin
            set_en(3'($urandom_range(0, 7)));
            check_lengths("R5 random mask");
        end

        set_en(3'b111);
        for (int t = 0; t <= 4; t += 2) begin
            int w;
            logic [3:0] op;
            logic [15:0] msk;
            w  = (t == 0) ? 8 : ((t == 2) ? 5 : 7);
            op = (t == 0) ? OP_BSCAN : ((t == 2) ? OP_SWITCH : OP_OTP);
            msk = 16'((1 << w) - 1);
            v  = 16'($urandom) & msk;
            v2 = 16'($urandom) & msk;
            ir_sel(t, op);
            dr_sel(t, w, v, cap);
            chk("R8 placeholder initial", {16'b0, cap}, 0);
            dr_sel(t, w, v2, cap);
            chk("R8 placeholder readback", {16'b0, cap}, {16'b0, v});
        end

        set_en(3'b100);
        ir_sel(4, OP_OTP);
        dr_sel(4, 7, 16'h11, cap);
        chk("R5 OTP alone keeps position", {16'b0, cap}, {16'b0, v2});

        set_en(3'b111);
        ir_sel(3, OP_CORE);
        for (int it = 0; it < 24; it++) begin
            core_cmd_t c;
            logic [15:0] exp;
            c.wr   = (it < 4) ? 1'b1 : 1'($urandom_range(0, 1));
            c.addr = (it < 4) ? CORE_AW'(it) : CORE_AW'($urandom_range(0, 3));
            c.data = CORE_DW'($urandom);
            exp = {5'b0, 1'b0, rd_m, rf_m[rd_m]};
            dr_sel(3, CORE_W, {5'b0, c}, cap);
            chk("R7 core capture", {16'b0, cap}, {16'b0, exp});
            rd_m = c.addr;
            if (c.wr) rf_m[c.addr] = c.data;
        end

        set_en(3'b111);
        begin
            logic o2;
            repeat (5) step(1'b1, 1'b0, o2);
            step(1'b0, 1'b0, o2);
        end
        en_m = '0;
        check_lengths("R6 after tms reset");
        set_en(3'b000);

        chk("R9 tdo_oe high in every shift cycle", oe_bad, 0);

        set_en(3'b111);
        do_reset();
        step(1'b0, 1'b0, o);
        check_lengths("R1 after trst");
        set_en(3'b010);
        ir_sel(3, OP_CORE);
        dr_sel(3, CORE_W, 16'h0, cap);
        chk("R1 core registers cleared", {16'b0, cap}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule